// File: doc/BRIEF.md
# Sector Write-Protection Controller

This block decides which sectors of a NOR flash main array may be erased or programmed. It keeps one protection flag for each protection group, where a group is a small run of neighbouring sectors. A flag is raised one group at a time. Flags can only be lowered all together, through a single erase-all command. Flops stand in for the non-volatile storage, and reset returns every item to its factory state.

Commands arrive on a one-cycle request strobe carrying an opcode, a sector index and a 64-bit key. Each command gets exactly one response pulse on the next cycle, flagged as success or as an error with a cause code. Three further mechanisms restrict the erase-all path:
- An optional password mode lets the flags change only after the stored key has been presented.
- A one-time master lock blocks erase-all permanently.
- A budget allows only a fixed number of erase-alls, reflecting the small endurance of the flag storage.

Two query paths run beside the command path. A combinational check reports whether a main-array address may be written. A registered status read reports whether a given sector is protected.

With the defaults there are 11 sectors. Sectors 0 to 3 form group 0. After that, each group holds 2 consecutive sectors: group 1 is sectors 4 and 5, group 2 is 6 and 7, group 3 is 8 and 9, and group 4 is sector 10 alone. The erase-all budget is 100.

Top module: `sector_guard`

## Requirements
- R1: Sector s belongs to group 0 when s < 4, and otherwise to group 1 + (s-4)/2. `statLocked` shows the flag of `statSector`'s group one clock after `statSector` is sampled. For sector indices of 11 and above it shows 1.
- R2: `accAllowed` is 1 exactly when the sector field (the upper 4 bits of `accAddr`) is below 11 and that sector's group flag is clear. It follows flag changes combinationally.
- R3: After reset, all flags are clear, password mode and the master lock are off, the erase-all count is zero, and `rspDone` is low.
- R4: Opcode 0 (raise flag) sets the flag of the addressed sector's group and changes no other flag. If that group's flag is already set, the command fails with cause 1 and nothing changes.
- R5: Opcode 1 (erase-all) clears every flag at once and counts one erase-all. No command clears a single flag.
- R6: Opcode 5 stores `cmdKey` as the password and enters password mode; a second opcode 5 fails with cause 5. In password mode without a key match, opcodes 0 and 1 fail with cause 3 and change nothing. Opcode 2 outside password mode fails with cause 5.
- R7: Opcode 2 with a matching key sets the unlocked state. A mismatching key fails with cause 3 and drops the unlocked state. Opcode 4 drops the unlocked state and succeeds.
- R8: Opcode 3 sets the master lock, which no command clears and which always succeeds. Afterwards, erase-all fails with cause 2 and leaves all flags unchanged, while opcode 0 still works.
- R9: After 100 successful erase-alls, further erase-alls fail with cause 4 and leave all flags unchanged. Reset restores the budget.
- R10: Every command gives `rspDone` high for exactly the next cycle only. `rspErr` is high only together with `rspDone`, and `rspCause` is 0 on success.
- R11: Opcode 0 for a sector index of 11 or above fails with cause 5. Opcodes 6 and 7 fail with cause 5.
- R12: Error priority is as follows. For erase-all, the password gate (3) comes before the master lock (2), which comes before the budget (4). For opcode 0, the password gate (3) comes before a bad sector (5), which comes before an already-set flag (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset to factory state |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 3 | Opcode |
| cmdSector | input | 4 | Target sector index for opcode 0 |
| cmdKey | input | 64 | Key for opcodes 2 and 5 |
| rspDone | output | 1 | Response pulse, one cycle after the command |
| rspErr | output | 1 | Command was refused |
| rspCause | output | 3 | Refusal cause, 0 on success |
| statSector | input | 4 | Sector index for the status read |
| statLocked | output | 1 | Registered protection status of `statSector` |
| accAddr | input | 8 | Main-array address: sector in the upper 4 bits, offset in the lower 4 |
| accAllowed | output | 1 | Erase or program of `accAddr` is permitted |

## Verification
After each flag change, the bench sweeps every sector index, including the out-of-range ones, through both query paths. This catches a group table that is off by one at a group boundary, and a raise that spills into a neighbouring flag. It walks the password life cycle (wrong key, right key, relock, wrong key after unlock) and checks that a wrong key really re-locks, rather than leaving the previous unlock in force. It drains the erase-all budget to exactly 100 and then stacks the master lock on top of it. A design with an off-by-one counter, or with the refusal causes checked in the wrong order, would report the wrong cause or erase flags it must keep.

// File: rtl/sguard_pkg.sv
package sguard_pkg;

  localparam logic [2:0] OP_PROG    = 3'd0;
  localparam logic [2:0] OP_ERASE   = 3'd1;
  localparam logic [2:0] OP_KEY     = 3'd2;
  localparam logic [2:0] OP_MASTER  = 3'd3;
  localparam logic [2:0] OP_RELOCK  = 3'd4;
  localparam logic [2:0] OP_PWDMODE = 3'd5;

  typedef enum logic [2:0] {
    CS_OK      = 3'd0,
    CS_TARGET  = 3'd1,
    CS_BLOCKED = 3'd2,
    CS_KEY     = 3'd3,
    CS_BUDGET  = 3'd4,
    CS_ARG     = 3'd5
  } cause_e;

  typedef struct packed {
    logic setBit;
    logic clearAll;
    logic setUnlock;
    logic clrUnlock;
    logic setMaster;
    logic setPwd;
  } strobe_t;

endpackage

// File: rtl/sguard_grpmap.sv
module sguard_grpmap #(
  parameter int NUM_SECTORS  = 11,
  parameter int HEAD_SECTORS = 4,
  parameter int TAIL_SIZE    = 2,
  parameter int SECT_BITS    = 4,
  parameter int GRP_BITS     = 3
) (
  input  logic [SECT_BITS-1:0] sect,
  output logic [GRP_BITS-1:0]  grp,
  output logic                 inRange
);

  logic [GRP_BITS-1:0] grpTab [NUM_SECTORS];

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_tab
    localparam int GIDX = (i < HEAD_SECTORS) ? 0 : 1 + (i - HEAD_SECTORS) / TAIL_SIZE;
    assign grpTab[i] = GRP_BITS'(GIDX);
  end

  always_comb begin
    inRange = (int'(sect) < NUM_SECTORS);
    grp     = '0;
    for (int k = 0; k < NUM_SECTORS; k++) begin
      if (int'(sect) == k) grp = grpTab[k];
    end
  end

endmodule

// File: rtl/sguard_ctrl.sv
module sguard_ctrl
  import sguard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       tgtValid,
  input  logic       tgtSet,
  input  logic       pwdMode,
  input  logic       unlocked,
  input  logic       masterLock,
  input  logic       budgetLeft,
  input  logic       keyMatch,
  output strobe_t    stb,
  output logic       rspDone,
  output logic       rspErr,
  output logic [2:0] rspCause
);

  strobe_t nextStb;
  cause_e  cause;
  logic    gated;

  always_comb begin
    gated   = pwdMode && !unlocked;
    nextStb = '0;
    cause   = CS_OK;
    case (cmdOp)
      OP_PROG: begin
        if (gated)          cause = CS_KEY;
        else if (!tgtValid) cause = CS_ARG;
        else if (tgtSet)    cause = CS_TARGET;
        else                nextStb.setBit = 1'b1;
      end
      OP_ERASE: begin
        if (gated)            cause = CS_KEY;
        else if (masterLock)  cause = CS_BLOCKED;
        else if (!budgetLeft) cause = CS_BUDGET;
        else                  nextStb.clearAll = 1'b1;
      end
      OP_KEY: begin
        if (!pwdMode) cause = CS_ARG;
        else if (keyMatch) nextStb.setUnlock = 1'b1;
        else begin
          nextStb.clrUnlock = 1'b1;
          cause = CS_KEY;
        end
      end
      OP_MASTER: nextStb.setMaster = 1'b1;
      OP_RELOCK: nextStb.clrUnlock = 1'b1;
      OP_PWDMODE: begin
        if (pwdMode) cause = CS_ARG;
        else         nextStb.setPwd = 1'b1;
      end
      default: cause = CS_ARG;
    endcase
    if (!cmdValid) begin
      nextStb = '0;
      cause   = CS_OK;
    end
  end

  assign stb = nextStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspDone  <= 1'b0;
      rspErr   <= 1'b0;
      rspCause <= 3'd0;
    end else begin
      rspDone  <= cmdValid;
      rspErr   <= cmdValid && (cause != CS_OK);
      rspCause <= cause;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> rspDone);  // R10
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !rspDone);  // R10
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);  // R10

endmodule

// File: rtl/sguard_dp.sv
module sguard_dp
  import sguard_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int GRP_BITS   = 3,
  parameter int KEY_W      = 64,
  parameter int MAX_ERASE  = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [KEY_W-1:0]    cmdKey,
  input  logic [GRP_BITS-1:0] tgtGrp,
  input  logic                tgtValid,
  input  logic [GRP_BITS-1:0] stGrp,
  input  logic                stValid,
  input  logic [GRP_BITS-1:0] accGrp,
  input  logic                accValid,
  output logic                tgtSet,
  output logic                pwdMode,
  output logic                unlocked,
  output logic                masterLock,
  output logic                budgetLeft,
  output logic                keyMatch,
  output logic                statLocked,
  output logic                accAllowed
);

  localparam int CNT_W = $clog2(MAX_ERASE + 1);

  logic [NUM_GROUPS-1:0] protBits;
  logic [NUM_GROUPS-1:0] tgtOneHot;
  logic [KEY_W-1:0]      pwdKey;
  logic [CNT_W-1:0]      eraseCnt;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign tgtOneHot[g] = tgtValid && (int'(tgtGrp) == g);
  end

  assign tgtSet     = |(tgtOneHot & protBits);
  assign keyMatch   = (cmdKey == pwdKey);
  assign budgetLeft = (int'(eraseCnt) < MAX_ERASE);

  always_comb begin
    accAllowed = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (accValid && int'(accGrp) == g) accAllowed = !protBits[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protBits   <= '0;
      eraseCnt   <= '0;
      masterLock <= 1'b0;
    end else begin
      if (stb.clearAll) begin
        protBits <= '0;
        eraseCnt <= eraseCnt + 1'b1;
      end else if (stb.setBit) begin
        protBits <= protBits | tgtOneHot;
      end
      if (stb.setMaster) masterLock <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwdKey   <= '0;
      pwdMode  <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (stb.setPwd) begin
        pwdKey  <= cmdKey;
        pwdMode <= 1'b1;
      end
      if (stb.setUnlock)      unlocked <= 1'b1;
      else if (stb.clrUnlock) unlocked <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statLocked <= 1'b0;
    else begin
      statLocked <= 1'b1;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (stValid && int'(stGrp) == g) statLocked <= protBits[g];
      end
    end
  end

  AST_SINGLE_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBit |=> ($countones(protBits ^ $past(protBits)) <= 1));  // R4
  AST_NO_PARTIAL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clearAll |=> (($past(protBits) & ~protBits) == '0));  // R5
  AST_PWD_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (pwdMode && !unlocked) |-> !(stb.setBit || stb.clearAll));  // R6
  AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    masterLock |=> masterLock);  // R8
  AST_MASTER_NO_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    masterLock |-> !stb.clearAll);  // R8
  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |-> (int'(eraseCnt) < MAX_ERASE));  // R9

endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sguard_pkg::*;
#(
  parameter int NUM_SECTORS  = 11,
  parameter int HEAD_SECTORS = 4,
  parameter int TAIL_SIZE    = 2,
  parameter int OFF_BITS     = 4,
  parameter int KEY_W        = 64,
  parameter int MAX_ERASE    = 100
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  cmdValid,
  input  logic [2:0]                            cmdOp,
  input  logic [$clog2(NUM_SECTORS)-1:0]        cmdSector,
  input  logic [KEY_W-1:0]                      cmdKey,
  output logic                                  rspDone,
  output logic                                  rspErr,
  output logic [2:0]                            rspCause,
  input  logic [$clog2(NUM_SECTORS)-1:0]        statSector,
  output logic                                  statLocked,
  input  logic [$clog2(NUM_SECTORS)+OFF_BITS-1:0] accAddr,
  output logic                                  accAllowed
);

  localparam int SECT_BITS  = $clog2(NUM_SECTORS);
  localparam int NUM_GROUPS = 1 + (NUM_SECTORS - HEAD_SECTORS + TAIL_SIZE - 1) / TAIL_SIZE;
  localparam int GRP_BITS   = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  strobe_t             stb;
  logic [GRP_BITS-1:0] tgtGrp, stGrp, accGrp;
  logic                tgtValid, stValid, accValid;
  logic                tgtSet, pwdMode, unlocked, masterLock, budgetLeft, keyMatch;

  sguard_grpmap #(.NUM_SECTORS(NUM_SECTORS), .HEAD_SECTORS(HEAD_SECTORS),
    .TAIL_SIZE(TAIL_SIZE), .SECT_BITS(SECT_BITS), .GRP_BITS(GRP_BITS))
    u_mapCmd (.sect(cmdSector), .grp(tgtGrp), .inRange(tgtValid));

  sguard_grpmap #(.NUM_SECTORS(NUM_SECTORS), .HEAD_SECTORS(HEAD_SECTORS),
    .TAIL_SIZE(TAIL_SIZE), .SECT_BITS(SECT_BITS), .GRP_BITS(GRP_BITS))
    u_mapStat (.sect(statSector), .grp(stGrp), .inRange(stValid));

  sguard_grpmap #(.NUM_SECTORS(NUM_SECTORS), .HEAD_SECTORS(HEAD_SECTORS),
    .TAIL_SIZE(TAIL_SIZE), .SECT_BITS(SECT_BITS), .GRP_BITS(GRP_BITS))
    u_mapAcc (.sect(accAddr[SECT_BITS+OFF_BITS-1:OFF_BITS]), .grp(accGrp), .inRange(accValid));

  sguard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .tgtValid(tgtValid), .tgtSet(tgtSet), .pwdMode(pwdMode), .unlocked(unlocked),
    .masterLock(masterLock), .budgetLeft(budgetLeft), .keyMatch(keyMatch),
    .stb(stb), .rspDone(rspDone), .rspErr(rspErr), .rspCause(rspCause)
  );

  sguard_dp #(.NUM_GROUPS(NUM_GROUPS), .GRP_BITS(GRP_BITS), .KEY_W(KEY_W),
    .MAX_ERASE(MAX_ERASE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdKey(cmdKey),
    .tgtGrp(tgtGrp), .tgtValid(tgtValid), .stGrp(stGrp), .stValid(stValid),
    .accGrp(accGrp), .accValid(accValid), .tgtSet(tgtSet), .pwdMode(pwdMode),
    .unlocked(unlocked), .masterLock(masterLock), .budgetLeft(budgetLeft),
    .keyMatch(keyMatch), .statLocked(statLocked), .accAllowed(accAllowed)
  );

endmodule

// File: tb/sector_guard_test.sv
`timescale 1ns/1ps
module sector_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [3:0]  cmdSector = 4'd0;
  logic [63:0] cmdKey = 64'd0;
  logic        rspDone, rspErr, statLocked, accAllowed;
  logic [2:0]  rspCause;
  logic [3:0]  statSector = 4'd0;
  logic [7:0]  accAddr = 8'd0;

  int errors = 0;
  int checks = 0;
  int eraseCount = 0;
  logic [4:0] expBits = 5'd0;
  bit finished = 0;

  localparam logic [63:0] KEY_A = 64'hC0DE_5EED_1234_ABCD;
  localparam logic [63:0] KEY_B = 64'hC0DE_5EED_1234_ABCC;

  always #10 clk = ~clk;

  sector_guard uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSector(cmdSector), .cmdKey(cmdKey), .rspDone(rspDone), .rspErr(rspErr),
    .rspCause(rspCause), .statSector(statSector), .statLocked(statLocked),
    .accAddr(accAddr), .accAllowed(accAllowed)
  );

  function automatic int grpOf(int s);
    return (s < 4) ? 0 : 1 + (s - 4) / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] op, input int sec, input logic [63:0] key,
                       input int expCause, input string req);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdSector = 4'(sec); cmdKey = key;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(rspDone === 1'b1, req, "rspDone", int'(rspDone), 1);
    chk(rspErr === (expCause != 0), req, "rspErr", int'(rspErr), int'(expCause != 0));
    chk(int'(rspCause) == expCause, req, "rspCause", int'(rspCause), expCause);
    @(negedge clk);
    chk(rspDone === 1'b0, "R10", "rspDone after pulse", int'(rspDone), 0);
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 16; s++) begin
      int expL;
      @(negedge clk);
      statSector = 4'(s);
      accAddr = {4'(s), 4'(s * 5)};
      expL = (s >= 11) ? 1 : int'(expBits[grpOf(s)]);
      #1;
      chk(accAllowed === (expL == 0), {req, "/R2"}, $sformatf("accAllowed s=%0d", s),
          int'(accAllowed), int'(expL == 0));
      @(posedge clk);
      @(negedge clk);
      chk(int'(statLocked) == expL, {req, "/R1"}, $sformatf("statLocked s=%0d", s),
          int'(statLocked), expL);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expBits = 5'd0; eraseCount = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int progSecs[5] = '{2, 5, 6, 9, 10};
    doReset();
    @(negedge clk);
    chk(rspDone === 1'b0, "R3", "rspDone idle", int'(rspDone), 0);
    sweep("R3");

    // R4: raise each group through one of its sectors
    foreach (progSecs[i]) begin
      doCmd(3'd0, progSecs[i], 64'd0, 0, "R4");
      expBits[grpOf(progSecs[i])] = 1'b1;
      sweep("R4");
    end
    doCmd(3'd0, 0, 64'd0, 1, "R4");
    // R11: bad sector and undefined opcodes
    doCmd(3'd0, 11, 64'd0, 5, "R11");
    doCmd(3'd0, 15, 64'd0, 5, "R11");
    doCmd(3'd6, 1, 64'd0, 5, "R11");
    doCmd(3'd7, 1, 64'd0, 5, "R11");
    doCmd(3'd2, 0, KEY_A, 5, "R6");

    // R5: erase-all
    doCmd(3'd1, 0, 64'd0, 0, "R5");
    expBits = 5'd0; eraseCount++;
    sweep("R5");
    doCmd(3'd0, 4, 64'd0, 0, "R4");
    expBits[1] = 1'b1;

    // R6 / R7: password mode
    doCmd(3'd5, 0, KEY_A, 0, "R6");
    doCmd(3'd0, 8, 64'd0, 3, "R6");
    doCmd(3'd1, 0, 64'd0, 3, "R6");
    sweep("R6");
    doCmd(3'd2, 0, KEY_B, 3, "R7");
    doCmd(3'd2, 0, KEY_A, 0, "R7");
    doCmd(3'd0, 8, 64'd0, 0, "R7");
    expBits[3] = 1'b1;
    doCmd(3'd5, 0, KEY_B, 5, "R6");
    doCmd(3'd2, 0, KEY_B, 3, "R7");
    doCmd(3'd0, 0, 64'd0, 3, "R7");
    doCmd(3'd2, 0, KEY_A, 0, "R7");
    doCmd(3'd4, 0, 64'd0, 0, "R7");
    doCmd(3'd0, 0, 64'd0, 3, "R7");
    sweep("R7");
    doCmd(3'd2, 0, KEY_A, 0, "R7");
    doCmd(3'd1, 0, 64'd0, 0, "R5");
    expBits = 5'd0; eraseCount++;
    sweep("R5");

    // R9: drain the erase budget
    while (eraseCount < 100) begin
      doCmd(3'd1, 0, 64'd0, 0, "R9");
      eraseCount++;
    end
    doCmd(3'd0, 10, 64'd0, 0, "R9");
    expBits[4] = 1'b1;
    doCmd(3'd1, 0, 64'd0, 4, "R9");
    sweep("R9");

    // R8 / R12: master lock on top of an exhausted budget
    doCmd(3'd3, 0, 64'd0, 0, "R8");
    doCmd(3'd1, 0, 64'd0, 2, "R12");
    doCmd(3'd0, 0, 64'd0, 0, "R8");
    expBits[0] = 1'b1;
    doCmd(3'd3, 0, 64'd0, 0, "R8");
    doCmd(3'd1, 0, 64'd0, 2, "R8");
    sweep("R8");
    doCmd(3'd4, 0, 64'd0, 0, "R7");
    doCmd(3'd1, 0, 64'd0, 3, "R12");
    doCmd(3'd0, 12, 64'd0, 3, "R12");
    doCmd(3'd2, 0, KEY_A, 0, "R7");
    doCmd(3'd0, 12, 64'd0, 5, "R12");
    doCmd(3'd0, 1, 64'd0, 1, "R12");
    sweep("R12");

    // R3: reset restores factory state and budget
    doReset();
    sweep("R3");
    doCmd(3'd0, 7, 64'd0, 0, "R3");
    expBits[2] = 1'b1;
    doCmd(3'd1, 0, 64'd0, 0, "R3");
    expBits = 5'd0;
    doCmd(3'd2, 0, KEY_A, 5, "R3");
    sweep("R3");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule